// File: doc/BRIEF.md
# SPI Master Byte Exchange Engine

This engine runs a single full-duplex SPI burst of 8-bit words from a small set of control settings. Software programs the mode bits and writes the start bit. The engine then selects a slave and exchanges bytes until the programmed burst length is used up. Each outgoing byte comes from a TX FIFO through a valid/pop handshake, and each incoming byte goes to an RX FIFO through a push strobe. When the burst is over, the engine raises a one-cycle completion pulse and the start bit drops back to zero.

The serial clock is paced by an enable pulse from an external divider. Each enable pulse produces one clock half-period. Two separate counts are sampled at start. The burst count sets how many bytes are exchanged. The transmit count sets how many of those bytes are taken from the TX FIFO. Once the transmit count is spent, zero bytes are sent for the rest of the burst. Received bytes can be dropped for transmit-only transfers. Chip select is either driven automatically around the burst or held by software at a fixed level.

Top module: `spi_xfer_engine`

## Requirements
- R1: The control word uses these bit positions: bit0 phase, bit1 clock idle level, bit2 select polarity (1 = active high), bits5:4 select index, bit6 manual select, bit7 manual level, bit8 drop received bytes, bit12 LSB first, bit31 start. It reads back unchanged. While start is 1, writes are ignored. Start clears itself in the same cycle that the completion pulse appears.
- R2: With bit6 = 0, the indexed select line is at its active level from start until the burst ends, and at the inactive level afterwards. All other lines always stay at the inactive level, so at most one line is active at a time.
- R3: With bit6 = 1, the indexed select line follows bit7 whether or not a burst is running. All other lines stay at the inactive level.
- R4: Between bytes and outside bursts, the serial clock rests at the level in bit1. While a transmit byte is owed and the TX FIFO reports no data, the clock is held and no edges occur.
- R5: With phase 0, MOSI changes only on trailing edges and is sampled on leading edges, with the first bit presented before the first leading edge. With phase 1, MOSI changes on leading edges and is sampled on trailing edges.
- R6: With bit12 = 0, bit 7 of each byte goes out and comes in first. With bit12 = 1, bit 0 goes first.
- R7: Exactly min(transmit count, burst count) bytes are popped from the TX FIFO, one per byte of the burst from the start. The remaining bytes of the burst are sent as 0x00.
- R8: With bit8 = 0, one RX push per exchanged byte carries the byte sampled from MISO. With bit8 = 1, no push occurs.
- R9: A burst produces exactly one completion pulse. A burst count of 0 completes with no clock edges, no pops and no pushes.
- R10: Each byte takes exactly 16 clock edges, one per enable pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| burst_len | input | 24 | Total bytes in the burst, sampled at start |
| tx_len | input | 24 | Bytes to take from the TX FIFO, sampled at start |
| ctrl_rdata | output | 32 | Control word readback |
| xfer_done | output | 1 | One-cycle burst completion pulse |
| sclk_en | input | 1 | Half-period pulse from the clock divider |
| tx_valid | input | 1 | TX FIFO holds a byte |
| tx_data | input | 8 | TX FIFO head byte |
| tx_pop | output | 1 | Pop request to the TX FIFO |
| rx_push | output | 1 | Push strobe to the RX FIFO |
| rx_data | output | 8 | Received byte |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip select lines |

## Verification
Some properties are checked by assertions on every cycle:
- the control fields stay frozen while a burst runs;
- every pop corresponds to an owed transmit byte;
- no push occurs while received bytes are dropped;
- the completion pulse lasts one cycle;
- the clock returns to its idle level after every byte;
- MOSI holds across a phase-0 sampling edge;
- no more than one select line is active.

Other behaviour only the bench scenarios can show: bit order on the wire, zero fill after the transmit count runs out, the exact number of clock edges per burst, and the clock stall while the TX FIFO is empty. The bench loops MOSI back to MISO, so it also compares pushed bytes against the bytes seen on the wire.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int POS_CPHA  = 0;
  localparam int POS_CPOL  = 1;
  localparam int POS_CSPOL = 2;
  localparam int POS_IDX0  = 4;
  localparam int POS_MAN   = 6;
  localparam int POS_LVL   = 7;
  localparam int POS_DROP  = 8;
  localparam int POS_LSB   = 12;
  localparam int POS_START = 31;

  typedef struct packed {
    logic       start;
    logic       lsb_first;
    logic       drop_rx;
    logic       man_lvl;
    logic       man_en;
    logic [1:0] sel_idx;
    logic       sel_high;
    logic       cpol;
    logic       cpha;
  } eng_ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SHIFT, ST_BEND, ST_FINISH
  } eng_state_t;

endpackage

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_eng_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        burst_done,
  output eng_ctrl_t   ctrl,
  output logic [31:0] ctrl_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (cfg_we && !ctrl.start) begin
      ctrl.cpha      <= cfg_wdata[POS_CPHA];
      ctrl.cpol      <= cfg_wdata[POS_CPOL];
      ctrl.sel_high  <= cfg_wdata[POS_CSPOL];
      ctrl.sel_idx   <= cfg_wdata[POS_IDX0+1:POS_IDX0];
      ctrl.man_en    <= cfg_wdata[POS_MAN];
      ctrl.man_lvl   <= cfg_wdata[POS_LVL];
      ctrl.drop_rx   <= cfg_wdata[POS_DROP];
      ctrl.lsb_first <= cfg_wdata[POS_LSB];
      ctrl.start     <= cfg_wdata[POS_START];
    end else if (burst_done) begin
      ctrl.start <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rdata = '0;
    ctrl_rdata[POS_CPHA]              = ctrl.cpha;
    ctrl_rdata[POS_CPOL]              = ctrl.cpol;
    ctrl_rdata[POS_CSPOL]             = ctrl.sel_high;
    ctrl_rdata[POS_IDX0+1:POS_IDX0]   = ctrl.sel_idx;
    ctrl_rdata[POS_MAN]               = ctrl.man_en;
    ctrl_rdata[POS_LVL]               = ctrl.man_lvl;
    ctrl_rdata[POS_DROP]              = ctrl.drop_rx;
    ctrl_rdata[POS_LSB]               = ctrl.lsb_first;
    ctrl_rdata[POS_START]             = ctrl.start;
  end

  logic [7:0] cfg_fields;
  assign cfg_fields = {ctrl.lsb_first, ctrl.drop_rx, ctrl.man_lvl, ctrl.man_en,
                       ctrl.sel_idx, ctrl.sel_high, ctrl.cpol ^ ctrl.cpha};

  // R1: mode fields cannot move while a burst is in flight
  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    ctrl.start |=> ($stable(cfg_fields) && $stable(ctrl.cpol)));

endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
  import spi_eng_pkg::*;
#(
  parameter int WORD  = 8,
  parameter int CNT_W = 24
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             drop_rx,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] tx_len,
  input  logic             tx_valid,
  input  logic [WORD-1:0]  tx_data,
  input  logic             byte_done,
  input  logic [WORD-1:0]  rx_byte,
  output logic             load,
  output logic [WORD-1:0]  load_byte,
  output logic             run,
  output logic             burst_done,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [WORD-1:0]  rx_data,
  output logic             xfer_done
);

  eng_state_t       state;
  logic [CNT_W-1:0] burst_rem;
  logic [CNT_W-1:0] tx_rem;
  logic             tx_owed;

  assign tx_owed    = (tx_rem != '0);
  assign load       = (state == ST_FETCH) && (burst_rem != '0) && (!tx_owed || tx_valid);
  assign load_byte  = tx_owed ? tx_data : '0;
  assign run        = (state == ST_SHIFT);
  assign burst_done = (state == ST_FINISH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      burst_rem <= '0;
      tx_rem    <= '0;
      tx_pop    <= 1'b0;
      rx_push   <= 1'b0;
      rx_data   <= '0;
      xfer_done <= 1'b0;
    end else begin
      tx_pop    <= 1'b0;
      rx_push   <= 1'b0;
      xfer_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            burst_rem <= burst_len;
            tx_rem    <= tx_len;
            state     <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (burst_rem == '0) begin
            state <= ST_FINISH;
          end else if (load) begin
            if (tx_owed) begin
              tx_rem <= tx_rem - 1'b1;
              tx_pop <= 1'b1;
            end
            state <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (byte_done) state <= ST_BEND;
        end
        ST_BEND: begin
          rx_push   <= !drop_rx;
          rx_data   <= rx_byte;
          burst_rem <= burst_rem - 1'b1;
          state     <= ST_FETCH;
        end
        ST_FINISH: begin
          xfer_done <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a pop only follows a cycle in which transmit bytes were still owed
  assert_pop_owed_R7: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> ($past(tx_rem) != '0));

  // R8: dropped bytes never reach the RX FIFO
  assert_no_push_drop_R8: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !drop_rx);

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int WORD = 8
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [WORD-1:0] load_byte,
  input  logic            run,
  input  logic            tick,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            lsb_first,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic [WORD-1:0] rx_byte,
  output logic            byte_done
);

  localparam int CW = $clog2(2 * WORD);
  localparam int KW = $clog2(WORD);
  localparam logic [CW-1:0] LAST = CW'(2 * WORD - 1);

  logic [CW-1:0]   cnt;
  logic [WORD-1:0] tx_hold;
  logic [KW-1:0]   kbit;
  logic            leading;
  logic            sample_now;

  assign kbit       = cnt[CW-1:1];
  assign leading    = ~cnt[0];
  assign sample_now = leading ^ cpha;
  assign byte_done  = run && tick && (cnt == LAST);

  function automatic logic bit_at(logic [WORD-1:0] b, int k, logic lsb);
    return lsb ? b[k] : b[WORD-1-k];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      tx_hold <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      rx_byte <= '0;
    end else begin
      if (!run) sclk <= cpol;
      if (load) begin
        tx_hold <= load_byte;
        cnt     <= '0;
        if (!cpha) mosi <= bit_at(load_byte, 0, lsb_first);
      end else if (run && tick) begin
        sclk <= ~sclk;
        cnt  <= cnt + 1'b1;
        if (sample_now) begin
          if (lsb_first) rx_byte[kbit] <= miso;
          else           rx_byte[WORD-1-int'(kbit)] <= miso;
        end else if (cpha) begin
          mosi <= bit_at(tx_hold, int'(kbit), lsb_first);
        end else if (int'(kbit) != WORD - 1) begin
          mosi <= bit_at(tx_hold, int'(kbit) + 1, lsb_first);
        end
      end
    end
  end

  // R4: after the last half-period the clock is back at its idle level
  assert_sclk_home_R4: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> (sclk == cpol));

  // R5: phase 0 keeps MOSI steady across the leading (sampling) edge
  assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (run && tick && leading && !cpha) |=> $stable(mosi));

endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int NCS = 4
)(
  input  logic           clk,
  input  logic           rst,
  input  logic           busy,
  input  logic           sel_high,
  input  logic [1:0]     sel_idx,
  input  logic           man_en,
  input  logic           man_lvl,
  output logic [NCS-1:0] cs
);

  generate
    for (genvar i = 0; i < NCS; i++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) begin
          cs[i] <= 1'b1;
        end else if (int'(sel_idx) == i) begin
          cs[i] <= man_en ? man_lvl : (busy ? sel_high : ~sel_high);
        end else begin
          cs[i] <= ~sel_high;
        end
      end
    end
  endgenerate

  // R2: never more than one line away from the inactive level
  assert_cs_single_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(cs ^ {NCS{~$past(sel_high)}}) <= 1);

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int WORD  = 8,
  parameter int CNT_W = 24,
  parameter int NCS   = 4
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] tx_len,
  output logic [31:0]      ctrl_rdata,
  output logic             xfer_done,
  input  logic             sclk_en,
  input  logic             tx_valid,
  input  logic [WORD-1:0]  tx_data,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [WORD-1:0]  rx_data,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic [NCS-1:0]   spi_cs
);

  eng_ctrl_t       ctrl;
  logic            burst_done;
  logic            load;
  logic [WORD-1:0] load_byte;
  logic            run;
  logic            byte_done;
  logic [WORD-1:0] rx_byte;

  spi_ctrl_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .burst_done (burst_done),
    .ctrl       (ctrl),
    .ctrl_rdata (ctrl_rdata)
  );

  spi_burst_seq #(.WORD(WORD), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (ctrl.start),
    .drop_rx    (ctrl.drop_rx),
    .burst_len  (burst_len),
    .tx_len     (tx_len),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .load       (load),
    .load_byte  (load_byte),
    .run        (run),
    .burst_done (burst_done),
    .tx_pop     (tx_pop),
    .rx_push    (rx_push),
    .rx_data    (rx_data),
    .xfer_done  (xfer_done)
  );

  spi_bit_shifter #(.WORD(WORD)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_byte (load_byte),
    .run       (run),
    .tick      (sclk_en),
    .cpol      (ctrl.cpol),
    .cpha      (ctrl.cpha),
    .lsb_first (ctrl.lsb_first),
    .miso      (spi_miso),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .rx_byte   (rx_byte),
    .byte_done (byte_done)
  );

  spi_cs_drive #(.NCS(NCS)) u_cs (
    .clk      (clk),
    .rst      (rst),
    .busy     (ctrl.start),
    .sel_high (ctrl.sel_high),
    .sel_idx  (ctrl.sel_idx),
    .man_en   (ctrl.man_en),
    .man_lvl  (ctrl.man_lvl),
    .cs       (spi_cs)
  );

endmodule

// File: tb/spi_xfer_engine_tb.sv
module spi_xfer_engine_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [23:0] burst_len = '0;
  logic [23:0] tx_len = '0;
  logic [31:0] ctrl_rdata;
  logic        xfer_done;
  logic        sclk_en = 1'b0;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_pop;
  logic        rx_push;
  logic [7:0]  rx_data;
  logic        spi_sclk;
  logic        spi_mosi;
  logic        spi_miso;
  logic [3:0]  spi_cs;

  assign spi_miso = spi_mosi;

  always #4 clk = ~clk;

  spi_xfer_engine u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .burst_len(burst_len), .tx_len(tx_len), .ctrl_rdata(ctrl_rdata),
    .xfer_done(xfer_done), .sclk_en(sclk_en), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] txq[$];
  logic [7:0] wireq[$];
  logic [7:0] rxq[$];
  int edges, pops, dones, cs_bad, bitk;
  logic [7:0] cur;
  logic prev_sclk;
  bit m_active = 0, m_cpol, m_cpha, m_lsb, m_pol, m_man, m_lvl, tx_hold_off = 0;
  bit [1:0] m_idx;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(bit cpha, bit cpol, bit pol, bit [1:0] idx,
                                         bit man, bit lvl, bit drop, bit lsb, bit start);
    logic [31:0] c = '0;
    c[0] = cpha; c[1] = cpol; c[2] = pol; c[5:4] = idx; c[6] = man;
    c[7] = lvl; c[8] = drop; c[12] = lsb; c[31] = start;
    return c;
  endfunction

  function automatic logic [3:0] cs_expect(bit busy);
    logic [3:0] v = {4{~m_pol}};
    v[m_idx] = m_man ? m_lvl : (busy ? m_pol : ~m_pol);
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (m_active && spi_sclk != prev_sclk) begin
        edges++;
        if ((spi_sclk != m_cpol) ^ m_cpha) begin
          if (m_lsb) cur[bitk] = spi_mosi; else cur[7-bitk] = spi_mosi;
          if (spi_cs != cs_expect(1'b1)) cs_bad++;
          bitk++;
          if (bitk == 8) begin wireq.push_back(cur); bitk = 0; end
        end
      end
      if (tx_pop) begin pops++; if (txq.size() > 0) void'(txq.pop_front()); end
      if (rx_push) rxq.push_back(rx_data);
      if (xfer_done) dones++;
      tx_valid = (txq.size() > 0) && !tx_hold_off && ($urandom_range(0, 3) != 0);
      tx_data  = (txq.size() > 0) ? txq[0] : 8'h00;
      sclk_en  = ($urandom_range(0, 2) != 0);
    end
    prev_sclk = spi_sclk;
  end

  task automatic wr(logic [31:0] v);
    @(negedge clk); cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic run_burst(bit cpha, bit cpol, bit pol, bit [1:0] idx, bit man, bit lvl,
                           bit drop, bit lsb, int blen, int tlen, bit late, bit midwr);
    logic [7:0] sent[$];
    logic [31:0] base;
    int npop, guard;
    sent.delete(); wireq.delete(); rxq.delete(); txq.delete();
    edges = 0; pops = 0; dones = 0; cs_bad = 0; bitk = 0;
    m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_pol = pol; m_idx = idx; m_man = man; m_lvl = lvl;
    for (int i = 0; i < tlen; i++) sent.push_back(8'($urandom_range(0, 255)));
    base = mk_cfg(cpha, cpol, pol, idx, man, lvl, drop, lsb, 1'b0);
    wr(base);
    repeat (3) @(negedge clk);
    chk(spi_sclk == cpol, "R4", "idle clock level", spi_sclk, cpol);
    chk(spi_cs == cs_expect(1'b0), "R2", "select lines before burst", spi_cs, cs_expect(1'b0));
    chk(ctrl_rdata == base, "R1", "readback", ctrl_rdata, base);
    if (!late) foreach (sent[i]) txq.push_back(sent[i]);
    tx_hold_off = late;
    m_active = 1;
    burst_len = 24'(blen); tx_len = 24'(tlen);
    wr(base | 32'h8000_0000);
    if (late) begin
      repeat (40) @(negedge clk);
      chk(edges == 0 && pops == 0, "R4", "clock held while TX empty", edges, 0);
      foreach (sent[i]) txq.push_back(sent[i]);
      tx_hold_off = 0;
    end
    if (midwr) begin
      repeat (5) @(negedge clk);
      chk(ctrl_rdata[31] == 1'b1, "R1", "start set while busy", ctrl_rdata[31], 1);
      wr(base ^ 32'h0000_1003);
    end
    guard = 0;
    while (dones == 0 && guard < 20000) begin @(negedge clk); guard++; end
    chk(ctrl_rdata == base, "R1", "start cleared, busy write ignored", ctrl_rdata, base);
    repeat (4) @(negedge clk);
    m_active = 0;
    npop = (tlen < blen) ? tlen : blen;
    chk(dones == 1, "R9", "completion pulses", dones, 1);
    chk(edges == 16 * blen, "R10", "clock edges", edges, 16 * blen);
    chk(pops == npop, "R7", "TX pops", pops, npop);
    chk(wireq.size() == blen, "R5", "bytes on wire", wireq.size(), blen);
    for (int i = 0; i < wireq.size(); i++) begin
      logic [7:0] e = (i < npop) ? sent[i] : 8'h00;
      chk(wireq[i] == e, "R6", $sformatf("wire byte %0d (R7 fill)", i), wireq[i], e);
    end
    if (drop) chk(rxq.size() == 0, "R8", "pushes while dropping", rxq.size(), 0);
    else begin
      chk(rxq.size() == blen, "R8", "push count", rxq.size(), blen);
      for (int i = 0; i < rxq.size() && i < wireq.size(); i++)
        chk(rxq[i] == wireq[i], "R8", $sformatf("rx byte %0d", i), rxq[i], wireq[i]);
    end
    chk(cs_bad == 0, man ? "R3" : "R2", "select at sample edges", cs_bad, 0);
    chk(spi_cs == cs_expect(1'b0), man ? "R3" : "R2", "select after burst", spi_cs, cs_expect(1'b0));
    chk(spi_sclk == cpol, "R4", "clock idle after burst", spi_sclk, cpol);
    txq.delete();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ctrl_rdata == 32'h0, "R1", "reset control word", ctrl_rdata, 0);
    chk(spi_cs == 4'hF, "R2", "reset select idle", spi_cs, 15);
    chk(xfer_done == 1'b0 && spi_sclk == 1'b0, "R9", "reset outputs", xfer_done, 0);

    // R3: manual select with no burst
    m_pol = 0; m_idx = 2; m_man = 1; m_lvl = 0;
    wr(mk_cfg(0, 0, 0, 2'd2, 1, 0, 0, 0, 0));
    repeat (2) @(negedge clk);
    chk(spi_cs == 4'b1011, "R3", "manual low on line 2", spi_cs, 4'b1011);
    m_pol = 1; m_lvl = 1; m_idx = 1;
    wr(mk_cfg(0, 0, 1, 2'd1, 1, 1, 0, 0, 0));
    repeat (2) @(negedge clk);
    chk(spi_cs == 4'b0010, "R3", "manual high on line 1", spi_cs, 4'b0010);

    // directed corners
    run_burst(0, 0, 0, 2'd0, 0, 0, 0, 0, 3, 3, 0, 0);  // mode 0 MSB first
    run_burst(1, 1, 1, 2'd3, 0, 0, 0, 1, 3, 3, 0, 0);  // mode 3 LSB first
    run_burst(0, 1, 0, 2'd1, 0, 0, 0, 0, 0, 3, 0, 0);  // R9 zero-length burst
    run_burst(1, 0, 0, 2'd2, 0, 0, 0, 0, 2, 2, 1, 0);  // R4 stall on empty TX
    run_burst(0, 0, 1, 2'd0, 0, 0, 0, 1, 4, 2, 0, 1);  // R7 zero fill, R1 busy write
    run_burst(1, 1, 0, 2'd1, 0, 0, 1, 0, 3, 6, 0, 0);  // R8 drop, R7 excess tx count
    run_burst(0, 0, 0, 2'd3, 1, 0, 0, 0, 2, 0, 0, 0);  // R3 manual during burst

    for (int n = 0; n < 14; n++) begin
      run_burst(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                2'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
                int'($urandom_range(1, 6)), int'($urandom_range(0, 8)), 0,
                ($urandom_range(0, 3) == 0));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule